// File: doc/BRIEF.md
# Serial Host Register Port

This block is the slave side of a four-wire serial control port. A host reaches a small register file through it, using an active-low select, a serial clock, a data-in line and a data-out line with its own output enable. Every access is a single frame of sixteen serial clock cycles. The first eight bits carry a read flag and a seven-bit address. The last eight bits carry the data: the host supplies it on a write, and the block returns it on a read. The port is live only while the mode-select input is high. Its system-clock side drives the configuration registers straight into the surrounding logic.

The serial pins and the mode input are brought into the system clock domain through two-flop synchronizers. All frame handling runs on edges that are detected in that domain. The block also watches a vector of alarm inputs, which are assumed to be synchronous to the system clock. Any change in an alarm is recorded in a sticky change register, and an active-low interrupt is driven while any sticky bit is set. Reading the sticky register returns its contents, clears it and releases the interrupt. An active-low master reset, with asynchronous assertion and synchronized release, returns every register to its default.

Top module: `hostRegPort`

## Requirements
- R1: After the master reset, configuration register i holds 8'hA0 + i, the sticky change register is zero, `intN` is high and `sdoEn` is low.
- R2: While `hostMode` is low, serial activity changes no register and `sdoEn` stays low.
- R3: Bits are sampled on rising `sclk` edges while `csN` is low. Rising edge 1 carries the read flag (1 = read, 0 = write). Rising edges 2 to 8 carry address bits A0 to A6. Rising edges 9 to 16 carry write data D0 to D7. A write to address 0 to NUM_CFG-1 updates `cfgOut[8*addr +: 8]`.
- R4: A write frame in which `csN` rises before the sixteenth rising edge leaves every register unchanged.
- R5: Clock edges after the sixteenth one in the same select period are ignored. No burst continues into further registers, and the committed data is that of edges 9 to 16.
- R6: On a read, `sdo` presents D0 after falling edge 8 and one further bit after each of falling edges 9 to 15, LSB first. `sdoEn` is high from falling edge 8 until `csN` rises.
- R7: `sdoEn` is low whenever `csN` is high, and it stays low for the whole of a write frame.
- R8: Address 0x20 reads the current alarm vector, and address 0x21 reads the sticky change register. Writes to any address outside 0 to NUM_CFG-1 are ignored. Reads of unmapped addresses return 0.
- R9: A change on any `alarmIn` bit sets the matching sticky bit and drives `intN` low.
- R10: A read of address 0x21 returns the sticky bits as they were when the address completed, then clears them. `intN` returns high unless a new change arrives.
- R11: When `csN` rises in the middle of a frame, the frame is abandoned. The next select period starts a fresh frame at bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low master reset |
| hostMode | input | 1 | High enables the serial port |
| csN | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| alarmIn | input | NUM_ALARM | Alarm status inputs, synchronous to clk |
| sdo | output | 1 | Serial read data |
| sdoEn | output | 1 | Output enable for sdo (low = high impedance) |
| intN | output | 1 | Active-low interrupt, low while any sticky bit is set |
| cfgOut | output | NUM_CFG*8 | Configuration registers, flattened, register 0 in the low byte |

## Verification
The hardest case to reach is a frame that stops short. Such a frame leaves a partially filled command or data shift register behind, and the next frame must neither commit it nor inherit its bit count. The stimulus aborts frames after chosen numbers of edges, runs frames with extra clocks at the end, and follows each with a complete access whose result is checked. A second hard case is a sticky read that races against the alarm history. Alarms are changed between frames in random order, then read back from both the live and the sticky address, with the interrupt level compared against a bench model.

// File: rtl/hostRegPkg.sv
package hostRegPkg;
  localparam int DATA_W    = 8;
  localparam int CMD_BITS  = 8;
  localparam int ADDR_W    = CMD_BITS - 1;
  localparam int FRAME_LEN = CMD_BITS + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  // Strobes from frame control to the datapath, all single-cycle except the levels.
  typedef struct packed {
    logic idle;        // level: port not selected or not in host mode
    logic cmdPhase;    // level: fewer than CMD_BITS bits taken so far
    logic sample;      // strobe: take one sdi bit
    logic cmdEdge;     // strobe: last command bit is being taken
    logic commitEdge;  // strobe: last data bit is being taken
    logic shiftOut;    // strobe: present the next read bit
    logic driveWin;    // level: read-data window is open
  } ctrlStrobes_t;

  function automatic logic [DATA_W-1:0] cfgDefault(input int idx);
    return DATA_W'(8'hA0 + idx);
  endfunction
endpackage

// File: rtl/hostRegSync.sv
module hostRegSync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RST_VAL}};
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hostRegCtrl.sv
module hostRegCtrl
  import hostRegPkg::*;
(
  input  logic         clk,
  input  logic         rstSync,
  input  logic         hostS,
  input  logic         csNS,
  input  logic         sclkS,
  output ctrlStrobes_t ctrl
);
  logic             sclkD;
  logic [CNT_W-1:0] bitCnt;
  logic             driveWin;
  logic             active;
  logic             rise;
  logic             fall;
  logic             room;

  assign active = hostS & ~csNS;
  assign rise   = sclkS & ~sclkD;
  assign fall   = ~sclkS & sclkD;
  assign room   = bitCnt < CNT_W'(FRAME_LEN);

  always_ff @(posedge clk or negedge rstSync) begin
    if (!rstSync) begin
      sclkD    <= 1'b0;
      bitCnt   <= '0;
      driveWin <= 1'b0;
    end else begin
      sclkD <= sclkS;
      if (!active) begin
        bitCnt   <= '0;
        driveWin <= 1'b0;
      end else begin
        if (rise && room) bitCnt <= bitCnt + 1'b1;
        if (fall && bitCnt == CNT_W'(CMD_BITS)) driveWin <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrl            = '0;
    ctrl.idle       = ~active;
    ctrl.cmdPhase   = bitCnt < CNT_W'(CMD_BITS);
    ctrl.sample     = active & rise & room;
    ctrl.cmdEdge    = ctrl.sample & (bitCnt == CNT_W'(CMD_BITS - 1));
    ctrl.commitEdge = ctrl.sample & (bitCnt == CNT_W'(FRAME_LEN - 1));
    ctrl.shiftOut   = active & fall & ~ctrl.cmdPhase & room;
    ctrl.driveWin   = driveWin;
  end
endmodule

// File: rtl/hostRegData.sv
module hostRegData
  import hostRegPkg::*;
#(
  parameter int              NUM_CFG     = 8,
  parameter int              NUM_ALARM   = 8,
  parameter logic [6:0]      STAT_ADDR   = 7'h20,
  parameter logic [6:0]      STICKY_ADDR = 7'h21
) (
  input  logic                        clk,
  input  logic                        rstSync,
  input  ctrlStrobes_t                ctrl,
  input  logic                        sdiS,
  input  logic [NUM_ALARM-1:0]        alarmIn,
  output logic                        sdo,
  output logic                        sdoEn,
  output logic                        intN,
  output logic [NUM_CFG*DATA_W-1:0]   cfgOut
);
  logic [CMD_BITS-2:0]   cmdSr;
  logic [CMD_BITS-1:0]   cmdNext;
  logic [ADDR_W-1:0]     addrNext;
  logic [ADDR_W-1:0]     addrReg;
  logic                  isRead;
  logic [DATA_W-2:0]     dataSr;
  logic [DATA_W-1:0]     dataNext;
  logic [DATA_W-1:0]     outSr;
  logic [DATA_W-1:0]     rdVal;
  logic                  sdoReg;
  logic [NUM_ALARM-1:0]  alarmPrev;
  logic [NUM_ALARM-1:0]  sticky;
  logic [NUM_ALARM-1:0]  stickyClr;
  logic [DATA_W-1:0]     cfgQ [NUM_CFG];

  assign cmdNext  = {sdiS, cmdSr};
  assign addrNext = cmdNext[CMD_BITS-1:1];
  assign dataNext = {sdiS, dataSr};

  // Frame shift registers and read-out path
  always_ff @(posedge clk or negedge rstSync) begin
    if (!rstSync) begin
      cmdSr   <= '0;
      dataSr  <= '0;
      addrReg <= '0;
      isRead  <= 1'b0;
      outSr   <= '0;
      sdoReg  <= 1'b0;
    end else if (ctrl.idle) begin
      isRead <= 1'b0;
    end else begin
      if (ctrl.sample && ctrl.cmdPhase)  cmdSr  <= cmdNext[CMD_BITS-1:1];
      if (ctrl.sample && !ctrl.cmdPhase) dataSr <= dataNext[DATA_W-1:1];
      if (ctrl.cmdEdge) begin
        addrReg <= addrNext;
        isRead  <= cmdNext[0];
        outSr   <= rdVal;
      end
      if (ctrl.shiftOut) begin
        sdoReg <= outSr[0];
        outSr  <= {1'b0, outSr[DATA_W-1:1]};
      end
    end
  end

  always_comb begin
    rdVal = '0;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (addrNext == ADDR_W'(i)) rdVal = cfgQ[i];
    end
    if (addrNext == STAT_ADDR)   rdVal = DATA_W'(alarmPrev);
    if (addrNext == STICKY_ADDR) rdVal = DATA_W'(sticky);
  end

  // Configuration register file
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    logic we;
    assign we = ctrl.commitEdge & ~isRead & (addrReg == ADDR_W'(g));
    always_ff @(posedge clk or negedge rstSync) begin
      if (!rstSync)  cfgQ[g] <= cfgDefault(g);
      else if (we)   cfgQ[g] <= dataNext;
    end
    assign cfgOut[g*DATA_W +: DATA_W] = cfgQ[g];
  end

  // Alarm change tracking, set wins over clear
  assign stickyClr = (ctrl.cmdEdge && cmdNext[0] && addrNext == STICKY_ADDR) ? sticky : '0;

  always_ff @(posedge clk or negedge rstSync) begin
    if (!rstSync) begin
      alarmPrev <= '0;
      sticky    <= '0;
    end else begin
      alarmPrev <= alarmIn;
      sticky    <= (sticky & ~stickyClr) | (alarmIn ^ alarmPrev);
    end
  end

  assign intN  = ~|sticky;
  assign sdo   = sdoReg;
  assign sdoEn = ctrl.driveWin & isRead;
endmodule

// File: rtl/hostRegPort.sv
module hostRegPort
  import hostRegPkg::*;
#(
  parameter int NUM_CFG   = 8,
  parameter int NUM_ALARM = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      hostMode,
  input  logic                      csN,
  input  logic                      sclk,
  input  logic                      sdi,
  input  logic [NUM_ALARM-1:0]      alarmIn,
  output logic                      sdo,
  output logic                      sdoEn,
  output logic                      intN,
  output logic [NUM_CFG*DATA_W-1:0] cfgOut
);
  localparam int NUM_SYNC = 4;
  localparam logic [NUM_SYNC-1:0] SYNC_RST = 4'b0100; // csN idles high

  logic [1:0]          rstPipe;
  logic                rstSync;
  logic [NUM_SYNC-1:0] rawIn;
  logic [NUM_SYNC-1:0] synIn;
  ctrlStrobes_t        ctrl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstPipe <= 2'b00;
    else       rstPipe <= {rstPipe[0], 1'b1};
  end
  assign rstSync = rstPipe[1];

  assign rawIn = {hostMode, csN, sclk, sdi};

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
    hostRegSync #(.STAGES(2), .RST_VAL(SYNC_RST[g])) u_sync (
      .clk (clk),
      .rstN(rstSync),
      .d   (rawIn[g]),
      .q   (synIn[g])
    );
  end

  hostRegCtrl u_ctrl (
    .clk    (clk),
    .rstSync(rstSync),
    .hostS  (synIn[3]),
    .csNS   (synIn[2]),
    .sclkS  (synIn[1]),
    .ctrl   (ctrl)
  );

  hostRegData #(.NUM_CFG(NUM_CFG), .NUM_ALARM(NUM_ALARM)) u_data (
    .clk    (clk),
    .rstSync(rstSync),
    .ctrl   (ctrl),
    .sdiS   (synIn[0]),
    .alarmIn(alarmIn),
    .sdo    (sdo),
    .sdoEn  (sdoEn),
    .intN   (intN),
    .cfgOut (cfgOut)
  );
endmodule

// File: rtl/hostRegChecker.sv
module hostRegChecker
  import hostRegPkg::*;
#(
  parameter int NUM_CFG   = 8,
  parameter int NUM_ALARM = 8
) (
  input logic                      clk,
  input logic                      rstSync,
  input logic                      hostMode,
  input logic                      csN,
  input logic [NUM_ALARM-1:0]      alarmIn,
  input logic                      sdo,
  input logic                      sdoEn,
  input logic                      intN,
  input logic [NUM_CFG*DATA_W-1:0] cfgOut,
  input ctrlStrobes_t              ctrl
);
  // R2: host mode low for long enough keeps the output released
  assert_host_gate_R2: assert property (@(posedge clk) disable iff (!rstSync)
    (!hostMode && !$past(hostMode) && !$past(hostMode, 2) && !$past(hostMode, 3)) |-> !sdoEn);

  // R7: deselected port keeps the output released
  assert_cs_release_R7: assert property (@(posedge clk) disable iff (!rstSync)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !sdoEn);

  // R4: configuration only moves on a full-frame commit
  assert_cfg_full_frame_R4: assert property (@(posedge clk) disable iff (!rstSync)
    (cfgOut != $past(cfgOut)) |-> $past(ctrl.commitEdge));

  // R6: read data holds between shift strobes
  assert_sdo_hold_R6: assert property (@(posedge clk) disable iff (!rstSync)
    (sdoEn && $past(sdoEn) && !$past(ctrl.shiftOut)) |-> $stable(sdo));

  // R9: any alarm change raises the interrupt next cycle
  assert_alarm_irq_R9: assert property (@(posedge clk) disable iff (!rstSync)
    ($past(rstSync) && alarmIn != $past(alarmIn)) |=> !intN);

  // R10: interrupt only releases after a command completes
  assert_irq_release_R10: assert property (@(posedge clk) disable iff (!rstSync)
    $rose(intN) |-> $past(ctrl.cmdEdge));
endmodule

bind hostRegPort hostRegChecker #(.NUM_CFG(NUM_CFG), .NUM_ALARM(NUM_ALARM)) u_chk (
  .clk     (clk),
  .rstSync (rstSync),
  .hostMode(hostMode),
  .csN     (csN),
  .alarmIn (alarmIn),
  .sdo     (sdo),
  .sdoEn   (sdoEn),
  .intN    (intN),
  .cfgOut  (cfgOut),
  .ctrl    (ctrl)
);

// File: tb/hostRegPort_tb.sv
`timescale 1ns/1ps
module hostRegPort_tb;
  localparam int NUM_CFG   = 8;
  localparam int NUM_ALARM = 8;
  localparam int HALF      = 8;
  localparam logic [6:0] A_STAT   = 7'h20;
  localparam logic [6:0] A_STICKY = 7'h21;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostMode = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [NUM_ALARM-1:0] alarmIn = '0;
  logic sdo, sdoEn, intN;
  logic [NUM_CFG*8-1:0] cfgOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] cfgModel [NUM_CFG];
  logic [NUM_ALARM-1:0] stickyModel;

  always #2 clk = ~clk;

  hostRegPort #(.NUM_CFG(NUM_CFG), .NUM_ALARM(NUM_ALARM)) u_dut (
    .clk(clk), .rstN(rstN), .hostMode(hostMode), .csN(csN), .sclk(sclk),
    .sdi(sdi), .alarmIn(alarmIn), .sdo(sdo), .sdoEn(sdoEn), .intN(intN),
    .cfgOut(cfgOut)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] expRead(input logic [6:0] a);
    if (a < NUM_CFG)     return cfgModel[a];
    if (a == A_STAT)     return 8'(alarmIn);
    if (a == A_STICKY)   return 8'(stickyModel);
    return 8'h00;
  endfunction

  function automatic logic [NUM_CFG*8-1:0] cfgPacked();
    logic [NUM_CFG*8-1:0] v;
    for (int i = 0; i < NUM_CFG; i++) v[i*8 +: 8] = cfgModel[i];
    return v;
  endfunction

  // One select period with nEdges serial clocks; rdata collects sdo before rising edges 9..16.
  task automatic frame(input bit rd, input logic [6:0] addr, input logic [7:0] wdata,
                       input int nEdges, input bit expDrive,
                       output logic [7:0] rdata, output bit enOk);
    logic [15:0] bits;
    bits  = {wdata, addr, rd};
    rdata = '0;
    enOk  = 1'b1;
    csN   = 1'b0;
    waitClk(HALF);
    for (int k = 1; k <= nEdges; k++) begin
      sdi = (k <= 16) ? bits[k-1] : ~wdata[(k-1) % 8];
      waitClk(HALF);
      if (k >= 9 && k <= 16) begin
        rdata[k-9] = sdo;
        if (sdoEn !== expDrive) enOk = 1'b0;
      end
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
    waitClk(HALF);
    csN = 1'b1;
    waitClk(2 * HALF);
  endtask

  task automatic doWrite(input logic [6:0] addr, input logic [7:0] d, input int n, input string req);
    logic [7:0] rd; bit en;
    frame(1'b0, addr, d, n, 1'b0, rd, en);
    check(en, {req, " R7 sdoEn during write"}, 64'(en), 64'd1);
    check(sdoEn === 1'b0, {req, " R7 sdoEn after cs high"}, 64'(sdoEn), 64'd0);
  endtask

  task automatic doRead(input logic [6:0] addr, input string req);
    logic [7:0] rd, exp; bit en;
    exp = expRead(addr);
    frame(1'b1, addr, 8'h00, 16, 1'b1, rd, en);
    check(rd === exp, {req, " read data"}, 64'(rd), 64'(exp));
    check(en, {req, " R6 sdoEn window"}, 64'(en), 64'd1);
    if (addr == A_STICKY) stickyModel = '0;
  endtask

  task automatic setAlarm(input logic [NUM_ALARM-1:0] v);
    stickyModel = stickyModel | (alarmIn ^ v);
    alarmIn = v;
    waitClk(4);
    check(intN === (stickyModel == 0), "R9 intN after alarm update", 64'(intN), 64'(stickyModel == 0));
  endtask

  task automatic resetModel();
    for (int i = 0; i < NUM_CFG; i++) cfgModel[i] = 8'hA0 + 8'(i);
    stickyModel = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd; bit en; int seedInit;
    seedInit = $urandom(32'h5EED_0042);
    resetModel();
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    // R1 reset state
    check(cfgOut === cfgPacked(), "R1 cfg defaults", 64'(cfgOut), 64'(cfgPacked()));
    check(intN === 1'b1, "R1 intN idle", 64'(intN), 64'd1);
    check(sdoEn === 1'b0, "R1 sdoEn idle", 64'(sdoEn), 64'd0);

    // R2 host mode low: write ignored, no drive on read
    frame(1'b0, 7'd3, 8'h5A, 16, 1'b0, rd, en);
    check(cfgOut === cfgPacked(), "R2 write ignored in hw mode", 64'(cfgOut), 64'(cfgPacked()));
    frame(1'b1, 7'd3, 8'h00, 16, 1'b0, rd, en);
    check(en, "R2 sdoEn low in hw mode", 64'(en), 64'd1);
    hostMode = 1'b1;
    waitClk(4);

    // R3 basic write and readback
    doWrite(7'd3, 8'h5A, 16, "R3");
    cfgModel[3] = 8'h5A;
    check(cfgOut === cfgPacked(), "R3 cfg after write", 64'(cfgOut), 64'(cfgPacked()));
    doRead(7'd3, "R6 R3 readback");
    doWrite(7'd0, 8'h81, 16, "R3");
    cfgModel[0] = 8'h81;
    doRead(7'd0, "R6 LSB-first");

    // R4 short write frames discarded
    doWrite(7'd1, 8'h33, 15, "R4");
    check(cfgOut === cfgPacked(), "R4 15-edge write discarded", 64'(cfgOut), 64'(cfgPacked()));
    doWrite(7'd2, 8'h44, 9, "R4");
    check(cfgOut === cfgPacked(), "R4 9-edge write discarded", 64'(cfgOut), 64'(cfgPacked()));

    // R5 extra clocks ignored
    doWrite(7'd4, 8'hC6, 24, "R5");
    cfgModel[4] = 8'hC6;
    check(cfgOut === cfgPacked(), "R5 extra clocks ignored", 64'(cfgOut), 64'(cfgPacked()));

    // R11 aborted frame then fresh frame
    frame(1'b1, 7'h55, 8'hFF, 5, 1'b0, rd, en);
    doWrite(7'd5, 8'h3C, 16, "R11");
    cfgModel[5] = 8'h3C;
    check(cfgOut === cfgPacked(), "R11 fresh frame after abort", 64'(cfgOut), 64'(cfgPacked()));

    // R8 address map
    doWrite(A_STAT, 8'hFF, 16, "R8");
    doWrite(7'h40, 8'hFF, 16, "R8");
    check(cfgOut === cfgPacked(), "R8 non-cfg writes ignored", 64'(cfgOut), 64'(cfgPacked()));
    doRead(7'h7F, "R8 unmapped read");

    // R9 / R10 alarms
    setAlarm(8'h12);
    doRead(A_STAT, "R8 live status");
    doRead(A_STICKY, "R10 sticky read");
    check(intN === 1'b1, "R10 intN released", 64'(intN), 64'd1);
    doRead(A_STICKY, "R10 sticky cleared");

    // Random mix
    for (int it = 0; it < 40; it++) begin
      int op;
      logic [6:0] a;
      logic [7:0] d;
      op = $urandom % 4;
      d  = 8'($urandom);
      case (op)
        0: begin
          a = ($urandom % 4 == 0) ? 7'($urandom) : 7'($urandom % NUM_CFG);
          doWrite(a, d, 16, "R3 random");
          if (a < NUM_CFG) cfgModel[a] = d;
          check(cfgOut === cfgPacked(), "R3 R8 random write", 64'(cfgOut), 64'(cfgPacked()));
        end
        1: begin
          a = ($urandom % 2 == 0) ? 7'($urandom % NUM_CFG) : 7'($urandom);
          doRead(a, "R6 R8 random read");
        end
        2: setAlarm(d);
        default: begin
          doRead(A_STICKY, "R10 random sticky");
          check(intN === 1'b1, "R10 intN after sticky read", 64'(intN), 64'd1);
        end
      endcase
    end

    // R1 mid-run reset
    alarmIn = '0;
    waitClk(4);
    rstN = 1'b0;
    waitClk(4);
    rstN = 1'b1;
    waitClk(5);
    resetModel();
    check(cfgOut === cfgPacked(), "R1 cfg after reset", 64'(cfgOut), 64'(cfgPacked()));
    check(intN === 1'b1, "R1 intN after reset", 64'(intN), 64'd1);
    doRead(A_STICKY, "R1 sticky after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule